// File: doc/BRIEF.md
# Static Dataflow Template Engine

This block executes a small dataflow graph held as a store of instruction templates. Each template carries an operation, two destination fields with enable bits, and a left and a right operand slot, each with its own presence flag. No program counter exists. An incoming token names a template, a port and a 16-bit value. It fills the matching slot and sets that slot's flag. A template whose two flags are both set is ready. A fixed-priority picker fires one ready template per cycle. The ALU result is sent as one token to each enabled destination.

A destination that names another template writes that template's slot directly, so graphs chain inside the block. A destination of all-ones sends the value out through a valid/ready output port, through a two-entry queue. Software first loads the templates through the program port. It then feeds operand tokens and collects the results that leave the graph.

Top module: `dfe_engine`

## Requirements
- R1: After reset, all presence flags are clear, `out_valid` is low and `ovf` is low.
- R2: A template fires only when both its left and right presence flags are set; a single operand never produces a result.
- R3: Operation codes: 0 = add, 1 = subtract (left minus right), 2 = multiply (low 16 bits of the product), 3 = pass the left value. All arithmetic wraps modulo 2^16.
- R4: Firing clears both presence flags of the fired template, so a fresh pair of tokens fires it again.
- R5: A token for a slot whose flag is already set is dropped and the slot keeps its old value. `ovf` is high for exactly the one cycle after that token's clock edge.
- R6: When several templates are ready, exactly one fires per cycle, lowest index first.
- R7: A destination field is {template index, port bit in the LSB: 0 = left, 1 = right}. A destination with its enable bit low emits nothing. A result for an internal destination is written at the edge that ends the firing cycle.
- R8: A destination equal to all-ones emits an output token carrying the result and the firing template index. If both destinations are all-ones, two tokens are emitted. `out_data` and `out_tag` hold steady while `out_valid` is high and `out_ready` is low. Up to two tokens wait in a queue, and firing stalls while the queue has no room.
- R9: A program write loads the operation and destinations of a template and clears both its presence flags. No template fires in a cycle that carries a program write.
- R10: Writes in one cycle are applied in the order input token, destination 1, destination 2. If an input token and a result target the same empty slot in one cycle, the input token is kept and the result is dropped with `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program write strobe |
| prog_idx | input | 3 | Template being loaded |
| prog_op | input | 2 | Operation code |
| prog_d1_en | input | 1 | Destination 1 enable |
| prog_d1 | input | 4 | Destination 1 field |
| prog_d2_en | input | 1 | Destination 2 enable |
| prog_d2 | input | 4 | Destination 2 field |
| tok_valid | input | 1 | Input token strobe |
| tok_idx | input | 3 | Target template of the input token |
| tok_port | input | 1 | Target slot (0 left, 1 right) |
| tok_data | input | 16 | Token value |
| out_valid | output | 1 | Output token available |
| out_ready | input | 1 | Consumer accepts the output token |
| out_data | output | 16 | Output token value |
| out_tag | output | 3 | Index of the template that produced it |
| ovf | output | 1 | One-cycle pulse: a token was dropped on an occupied slot |

## Verification
The hardest state to reach is several templates ready at the same moment, because only one input token arrives per cycle. The stimulus creates it by holding `out_ready` low. Two firings fill the output queue, and two more templates then become ready with no room to fire. Releasing `out_ready` drains the queue in firing order, which shows the lowest-index pick at the port. The same-cycle conflict between an input token and an internal result is set up by timing an input token to arrive on the edge where a chained result lands.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_MUL  = 2'd2,
    OP_PASS = 2'd3
  } dfe_op_e;

endpackage

// File: rtl/dfe_alu.sv
module dfe_alu
  import dfe_pkg::*;
#(
  parameter int DW = 16
) (
  input  dfe_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   y
);
  logic [2*DW-1:0] prod;

  always_comb begin
    prod = a * b;
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = prod[DW-1:0];
      default: y = a;
    endcase
  end
endmodule

// File: rtl/dfe_prio_pick.sv
module dfe_prio_pick #(
  parameter int NT = 8,
  localparam int IW = $clog2(NT)
) (
  input  logic [NT-1:0] req,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx
);
  always_comb begin
    gnt_vld = |req;
    gnt_idx = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (req[i]) gnt_idx = IW'(i);
    end
  end
endmodule

// File: rtl/dfe_out_queue.sv
module dfe_out_queue #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   push_cnt,
  input  logic [W-1:0] push_word,
  input  logic         pop_rdy,
  output logic         head_vld,
  output logic [W-1:0] head_word,
  output logic [1:0]   room
);
  logic [1:0]   cnt_q, cnt_n, cnt_a;
  logic [W-1:0] e_q [2];
  logic [W-1:0] e_n [2];
  logic         pop;

  assign head_vld  = (cnt_q != 2'd0);
  assign head_word = e_q[0];
  assign pop       = head_vld && pop_rdy;
  assign room      = 2'd2 - cnt_q + {1'b0, pop};

  always_comb begin
    e_n[0] = e_q[0];
    e_n[1] = e_q[1];
    if (pop) e_n[0] = e_q[1];
    cnt_a = cnt_q - {1'b0, pop};
    if (push_cnt != 2'd0) begin
      if (cnt_a == 2'd0) e_n[0] = push_word;
      else               e_n[1] = push_word;
    end
    if (push_cnt == 2'd2) e_n[1] = push_word;
    cnt_n = cnt_a + push_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    e_q[0] <= e_n[0];
    e_q[1] <= e_n[1];
  end
endmodule

// File: rtl/dfe_engine.sv
module dfe_engine
  import dfe_pkg::*;
#(
  parameter int NT = 8,
  parameter int DW = 16,
  localparam int IW = $clog2(NT),
  localparam int DESTW = IW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_we,
  input  logic [IW-1:0]    prog_idx,
  input  logic [1:0]       prog_op,
  input  logic             prog_d1_en,
  input  logic [DESTW-1:0] prog_d1,
  input  logic             prog_d2_en,
  input  logic [DESTW-1:0] prog_d2,
  input  logic             tok_valid,
  input  logic [IW-1:0]    tok_idx,
  input  logic             tok_port,
  input  logic [DW-1:0]    tok_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic [IW-1:0]    out_tag,
  output logic             ovf
);
  localparam logic [DESTW-1:0] EXT = '1;
  localparam int NW = 3;

  // template store
  dfe_op_e          op_q  [NT];
  dfe_op_e          op_n  [NT];
  logic [DESTW-1:0] d1_q  [NT];
  logic [DESTW-1:0] d1_n  [NT];
  logic [DESTW-1:0] d2_q  [NT];
  logic [DESTW-1:0] d2_n  [NT];
  logic [DW-1:0]    lv_q  [NT];
  logic [DW-1:0]    lv_n  [NT];
  logic [DW-1:0]    rv_q  [NT];
  logic [DW-1:0]    rv_n  [NT];
  logic [NT-1:0]    d1en_q, d1en_n, d2en_q, d2en_n;
  logic [NT-1:0]    lp_q, lp_n, rp_q, rp_n;
  logic             ovf_q, ovf_n;

  // firing path
  logic [NT-1:0]    rdy;
  logic             gnt_vld, fire;
  logic [IW-1:0]    gnt_idx;
  logic [DW-1:0]    result;
  logic             x1, x2;
  logic [1:0]       need, room, push_cnt;
  logic [DW+IW-1:0] head_word;

  // ordered slot writes: 0 input token, 1 destination 1, 2 destination 2
  logic             w_vld  [NW];
  logic [IW-1:0]    w_idx  [NW];
  logic             w_port [NW];
  logic [DW-1:0]    w_data [NW];

  assign rdy = lp_q & rp_q;

  dfe_prio_pick #(.NT(NT)) u_pick (
    .req     (rdy),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  dfe_alu #(.DW(DW)) u_alu (
    .op (op_q[gnt_idx]),
    .a  (lv_q[gnt_idx]),
    .b  (rv_q[gnt_idx]),
    .y  (result)
  );

  assign x1       = d1en_q[gnt_idx] && (d1_q[gnt_idx] == EXT);
  assign x2       = d2en_q[gnt_idx] && (d2_q[gnt_idx] == EXT);
  assign need     = {1'b0, x1} + {1'b0, x2};
  assign fire     = gnt_vld && !prog_we && (need <= room);
  assign push_cnt = fire ? need : 2'd0;

  dfe_out_queue #(.W(DW + IW)) u_outq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_cnt  (push_cnt),
    .push_word ({gnt_idx, result}),
    .pop_rdy   (out_ready),
    .head_vld  (out_valid),
    .head_word (head_word),
    .room      (room)
  );

  assign out_data = head_word[DW-1:0];
  assign out_tag  = head_word[DW+IW-1:DW];
  assign ovf      = ovf_q;

  always_comb begin
    w_vld[0]  = tok_valid;
    w_idx[0]  = tok_idx;
    w_port[0] = tok_port;
    w_data[0] = tok_data;
    w_vld[1]  = fire && d1en_q[gnt_idx] && !x1;
    w_idx[1]  = d1_q[gnt_idx][DESTW-1:1];
    w_port[1] = d1_q[gnt_idx][0];
    w_data[1] = result;
    w_vld[2]  = fire && d2en_q[gnt_idx] && !x2;
    w_idx[2]  = d2_q[gnt_idx][DESTW-1:1];
    w_port[2] = d2_q[gnt_idx][0];
    w_data[2] = result;
  end

  // next state of the template store
  always_comb begin
    op_n   = op_q;
    d1_n   = d1_q;
    d2_n   = d2_q;
    lv_n   = lv_q;
    rv_n   = rv_q;
    d1en_n = d1en_q;
    d2en_n = d2en_q;
    lp_n   = lp_q;
    rp_n   = rp_q;
    ovf_n  = 1'b0;
    if (prog_we) begin
      op_n[prog_idx]   = dfe_op_e'(prog_op);
      d1_n[prog_idx]   = prog_d1;
      d2_n[prog_idx]   = prog_d2;
      d1en_n[prog_idx] = prog_d1_en;
      d2en_n[prog_idx] = prog_d2_en;
      lp_n[prog_idx]   = 1'b0;
      rp_n[prog_idx]   = 1'b0;
    end
    if (fire) begin
      lp_n[gnt_idx] = 1'b0;
      rp_n[gnt_idx] = 1'b0;
    end
    for (int k = 0; k < NW; k++) begin
      if (w_vld[k]) begin
        if (!w_port[k]) begin
          if (lp_n[w_idx[k]]) ovf_n = 1'b1;
          else begin
            lp_n[w_idx[k]] = 1'b1;
            lv_n[w_idx[k]] = w_data[k];
          end
        end else begin
          if (rp_n[w_idx[k]]) ovf_n = 1'b1;
          else begin
            rp_n[w_idx[k]] = 1'b1;
            rv_n[w_idx[k]] = w_data[k];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q   <= '0;
      rp_q   <= '0;
      d1en_q <= '0;
      d2en_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      lp_q   <= lp_n;
      rp_q   <= rp_n;
      d1en_q <= d1en_n;
      d2en_q <= d2en_n;
      ovf_q  <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < NT; t++) begin
      op_q[t] <= op_n[t];
      d1_q[t] <= d1_n[t];
      d2_q[t] <= d2_n[t];
      lv_q[t] <= lv_n[t];
      rv_q[t] <= rv_n[t];
    end
  end
endmodule

// File: rtl/dfe_engine_chk.sv
module dfe_engine_chk #(
  parameter int NT = 8,
  parameter int DW = 16,
  localparam int IW = $clog2(NT)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fire,
  input logic [IW-1:0] gnt_idx,
  input logic [NT-1:0] rdy,
  input logic          tok_valid,
  input logic          ovf,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [IW-1:0] out_tag
);
  // R2: the fired template has both operands present
  a_r2_fire_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> rdy[gnt_idx]);

  // R6: no lower-index template was ready when one fired
  a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ((rdy & ((NT'(1) << gnt_idx) - NT'(1))) == '0));

  // R5: an overflow pulse follows a cycle that carried a slot write
  a_r5_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(tok_valid || fire));

  // R8: a held output token does not change
  a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));
endmodule

bind dfe_engine dfe_engine_chk #(.NT(NT), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fire      (fire),
  .gnt_idx   (gnt_idx),
  .rdy       (rdy),
  .tok_valid (tok_valid),
  .ovf       (ovf),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_tag   (out_tag)
);

// File: tb/tb_dfe_engine.sv
module tb_dfe_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] EXT = 4'hF;
  localparam int NV = 8;
  // {op, left, right, expected}
  localparam logic [49:0] VEC [NV] = '{
    {2'd0, 16'd3,    16'd4,    16'd7},
    {2'd0, 16'hFFFF, 16'd2,    16'd1},
    {2'd1, 16'd10,   16'd3,    16'd7},
    {2'd1, 16'd3,    16'd5,    16'hFFFE},
    {2'd2, 16'd300,  16'd300,  16'h5F90},
    {2'd2, 16'h1234, 16'd0,    16'd0},
    {2'd3, 16'hABCD, 16'h1111, 16'hABCD},
    {2'd1, 16'h8000, 16'd1,    16'h7FFF}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic prog_we, prog_d1_en, prog_d2_en, tok_valid, tok_port, out_ready;
  logic [2:0] prog_idx, tok_idx;
  logic [1:0] prog_op;
  logic [3:0] prog_d1, prog_d2;
  logic [15:0] tok_data;
  logic out_valid, ovf;
  logic [15:0] out_data;
  logic [2:0] out_tag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dfe_engine dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_idx(prog_idx), .prog_op(prog_op),
    .prog_d1_en(prog_d1_en), .prog_d1(prog_d1), .prog_d2_en(prog_d2_en), .prog_d2(prog_d2),
    .tok_valid(tok_valid), .tok_idx(tok_idx), .tok_port(tok_port), .tok_data(tok_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_tag(out_tag),
    .ovf(ovf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [2:0] idx, input logic [1:0] op,
                      input logic e1, input logic [3:0] d1, input logic e2, input logic [3:0] d2);
    prog_we = 1; prog_idx = idx; prog_op = op;
    prog_d1_en = e1; prog_d1 = d1; prog_d2_en = e2; prog_d2 = d2;
    @(negedge clk);
    prog_we = 0;
  endtask

  task automatic send(input logic [2:0] idx, input logic port, input logic [15:0] val);
    tok_valid = 1; tok_idx = idx; tok_port = port; tok_data = val;
    @(negedge clk);
    tok_valid = 0;
  endtask

  task automatic get_out(output logic [15:0] d, output logic [2:0] t, output bit got);
    got = 0; d = '0; t = '0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_valid) begin
        d = out_data; t = out_tag; got = 1;
        break;
      end
    end
  endtask

  task automatic quiet(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(req, out_valid, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [2:0] t;
    bit got;
    rst_n = 0; prog_we = 0; tok_valid = 0; out_ready = 1;
    prog_idx = 0; prog_op = 0; prog_d1_en = 0; prog_d1 = 0; prog_d2_en = 0; prog_d2 = 0;
    tok_idx = 0; tok_port = 0; tok_data = 0;
    repeat (3) @(negedge clk);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 ovf after reset", ovf, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 operation table, one external destination, destination 2 disabled (R7)
    for (int v = 0; v < NV; v++) begin
      prog(3'd0, VEC[v][49:48], 1'b1, EXT, 1'b0, 4'd0);
      send(3'd0, 1'b0, VEC[v][47:32]);
      send(3'd0, 1'b1, VEC[v][31:16]);
      get_out(d, t, got);
      check("R3 result present", got, 1);
      check("R3 result value", d, VEC[v][15:0]);
      check("R8 tag", t, 0);
      quiet("R7 disabled destination silent", 2);
    end

    // R2 single operand never fires; R5 overflow drops token
    prog(3'd0, 2'd0, 1'b1, EXT, 1'b0, 4'd0);
    send(3'd0, 1'b0, 16'd5);
    quiet("R2 one operand only", 4);
    send(3'd0, 1'b0, 16'd100);
    check("R5 ovf pulse", ovf, 1);
    @(negedge clk);
    check("R5 ovf one cycle", ovf, 0);
    send(3'd0, 1'b1, 16'd1);
    get_out(d, t, got);
    check("R5 old value kept", d, 16'd6);
    // R4 slot reuse after firing
    send(3'd0, 1'b0, 16'd20);
    send(3'd0, 1'b1, 16'd22);
    get_out(d, t, got);
    check("R4 refire value", d, 16'd42);
    check("R4 no overflow on reuse", ovf, 0);

    // R7 chained graph: t1 add -> t2 left and right; t2 mul -> external
    prog(3'd1, 2'd0, 1'b1, {3'd2, 1'b0}, 1'b1, {3'd2, 1'b1});
    prog(3'd2, 2'd2, 1'b1, EXT, 1'b0, 4'd0);
    send(3'd1, 1'b0, 16'd3);
    send(3'd1, 1'b1, 16'd4);
    get_out(d, t, got);
    check("R7 chain value", d, 16'd49);
    check("R7 chain tag", t, 3'd2);

    // R8 both destinations external
    prog(3'd7, 2'd3, 1'b1, EXT, 1'b1, EXT);
    send(3'd7, 1'b0, 16'h77);
    send(3'd7, 1'b1, 16'h0);
    get_out(d, t, got);
    check("R8 first of two", {t, d}, {3'd7, 16'h77});
    get_out(d, t, got);
    check("R8 second of two", {got, t, d}, {1'b1, 3'd7, 16'h77});

    // R6 / R8 backpressure and priority
    for (int i = 3; i <= 6; i++) prog(3'(i), 2'd3, 1'b1, EXT, 1'b0, 4'd0);
    out_ready = 0;
    send(3'd5, 1'b0, 16'd50); send(3'd5, 1'b1, 16'd0);
    send(3'd4, 1'b0, 16'd40); send(3'd4, 1'b1, 16'd0);
    send(3'd6, 1'b0, 16'd60); send(3'd6, 1'b1, 16'd0);
    send(3'd3, 1'b0, 16'd30); send(3'd3, 1'b1, 16'd0);
    repeat (3) @(negedge clk);
    check("R8 held valid", out_valid, 1);
    check("R8 held head", {out_tag, out_data}, {3'd5, 16'd50});
    out_ready = 1;
    for (int i = 0; i < 4; i++) begin
      logic [2:0] et;
      et = (i == 0) ? 3'd5 : (i == 1) ? 3'd4 : (i == 2) ? 3'd3 : 3'd6;
      check("R6 drain valid", out_valid, 1);
      check("R6 drain order", {out_tag, out_data}, {et, 16'(et) * 16'd10});
      @(negedge clk);
    end
    check("R8 drained", out_valid, 0);

    // R9 program write clears presence
    prog(3'd0, 2'd3, 1'b1, EXT, 1'b0, 4'd0);
    send(3'd0, 1'b0, 16'd8);
    prog(3'd0, 2'd3, 1'b1, EXT, 1'b0, 4'd0);
    send(3'd0, 1'b1, 16'd1);
    quiet("R9 presence cleared", 4);
    send(3'd0, 1'b0, 16'd9);
    get_out(d, t, got);
    check("R9 fires after reload", d, 16'd9);

    // R10 input token wins over a same-cycle result on one slot
    prog(3'd1, 2'd0, 1'b1, {3'd2, 1'b0}, 1'b0, 4'd0);
    prog(3'd2, 2'd3, 1'b1, EXT, 1'b0, 4'd0);
    send(3'd1, 1'b0, 16'd5);
    send(3'd1, 1'b1, 16'd6);
    send(3'd2, 1'b0, 16'd77);
    check("R10 ovf on collision", ovf, 1);
    send(3'd2, 1'b1, 16'd1);
    get_out(d, t, got);
    check("R10 input token kept", {t, d}, {3'd2, 16'd77});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule